// File: doc/BRIEF.md
# Dynamically Filled Loop Cache

This block is a small tagless instruction store that sits beside a processor's level-one instruction memory. It has a controller and a select output for the fetch multiplexer. The controller watches every fetch for a taken backward branch. That branch marks a loop, which runs from the branch target up to the branch itself. On the following pass through the loop, each instruction returned by the level-one memory is also written into the store. On the pass after that, fetches inside the loop are served from the store and the level-one request is withheld.

The store has no tags. A hit follows from the controller state and from the distance between the fetch PC and the loop start. Branch information arrives as flags from the decoder: a backward-branch flag, a taken flag, the backward distance in instruction words, and a flag for any other taken control-flow change. Any control-flow change other than the loop's own branch abandons filling or serving. A not-taken loop branch does the same, and so does a fetch outside the loop. In each of these cases the controller returns to idle.

A parameter picks between two variants. The strict variant ignores loops longer than the store. The prefix variant keeps the first DEPTH instructions of a longer loop and fetches the remainder from level-one memory.

Top module: `loop_cache`

## Requirements
- R1: After reset, and after any later reset, the controller is idle: `sel_buf_o` is 0 and `l1_req_o` equals `fetch_valid_i`.
- R2: A fetch at PC P with `bb_i`=1, `bb_taken_i`=1 and distance D defines the loop [P-D, P] and starts a fill. During the next pass, every fetch is taken from level-one memory (`sel_buf_o`=0, `l1_req_o`=1).
- R3: After a fill pass that ends with the loop branch taken, each later fetch in the loop gets `sel_buf_o`=1 and `l1_req_o`=0 in the same cycle the PC is presented. In that cycle `buf_data_o` equals the word captured at that PC during the fill pass.
- R4: With FLEXIBLE=0, a loop whose length D+1 exceeds DEPTH never engages, and every fetch of it comes from level-one memory.
- R5: With FLEXIBLE=1, a loop longer than DEPTH is still filled. Offsets 0 to DEPTH-1 from the loop start are then served from the store, and the higher offsets come from level-one memory while the controller stays engaged.
- R6: A fetch with `cof_i`=1 during a fill pass aborts the fill. No later fetch is served until a new detection and a complete fill pass have taken place.
- R7: A fetch with `cof_i`=1 while serving ends serving from the next fetch onward.
- R8: A fetch of the loop's own branch with `bb_taken_i`=0 returns the controller to idle. Re-entering the loop requires detection and a fill pass again.
- R9: A taken backward branch at a PC other than the current loop's branch, seen while filling or serving, starts a fill of the new loop.
- R10: A cycle with `fetch_valid_i`=0 leaves the controller state unchanged and ignores all branch flags. In that cycle both `sel_buf_o` and `l1_req_o` are 0.
- R11: A fetch outside the current loop's range while filling or serving is taken from level-one memory and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | A fetch is presented this cycle |
| fetch_pc_i | input | PC_W | Fetch address in instruction words |
| l1_data_i | input | DATA_W | Instruction returned by level-one memory this cycle |
| bb_i | input | 1 | Fetched instruction is a backward branch |
| bb_taken_i | input | 1 | That backward branch is taken |
| cof_i | input | 1 | Fetched instruction is another taken control-flow change |
| bb_dist_i | input | OFF_W | Backward distance of the branch in words |
| sel_buf_o | output | 1 | Fetch multiplexer picks the store output |
| buf_data_o | output | DATA_W | Store read data for the current PC |
| l1_req_o | output | 1 | Level-one fetch enable |

## Verification
A controller stuck in, or wrongly moved to, the serving state appears at the ports in the cycle of the next in-loop fetch. It shows as `sel_buf_o` asserted during a pass that should come from level-one memory, or as a missing select on a pass that should hit. A fill that writes the wrong slot or the wrong word does not show during the fill pass. It appears one loop pass later, as a mismatch on `buf_data_o` at the affected PC. To expose writes made while serving, the stimulus drives poisoned level-one data during serving passes. Loops longer than the store are driven into both variants at once, so the boundary between the stored prefix and the level-one remainder is checked at the exact offset.

// File: rtl/loop_cache_pkg.sv
package loop_cache_pkg;
  typedef enum logic [1:0] {
    LC_IDLE  = 2'd0,
    LC_FILL  = 2'd1,
    LC_FETCH = 2'd2
  } lc_state_e;
endpackage

// File: rtl/lc_range.sv
module lc_range #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 8,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  start_i,
  input  logic [OFF_W-1:0] dist_i,
  output logic             in_range_o,
  output logic             in_buf_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [PC_W-1:0] offset;

  assign offset     = pc_i - start_i;
  assign in_range_o = offset <= PC_W'(dist_i);
  assign in_buf_o   = offset < PC_W'(DEPTH);
  assign idx_o      = offset[IDX_W-1:0];
endmodule

// File: rtl/lc_store.sv
module lc_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  // combinational read so the mux can switch in the PC cycle
  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import loop_cache_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int OFF_W    = 8,
  parameter int DEPTH    = 32,
  parameter bit FLEXIBLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             bb_i,
  input  logic             bb_taken_i,
  input  logic             cof_i,
  input  logic [OFF_W-1:0] bb_dist_i,
  input  logic             in_range_i,
  output lc_state_e        state_o,
  output logic [PC_W-1:0]  start_o,
  output logic [PC_W-1:0]  end_o,
  output logic [OFF_W-1:0] dist_o
);
  lc_state_e        state_q, state_d;
  logic [PC_W-1:0]  start_q, start_d, end_q, end_d;
  logic [OFF_W-1:0] dist_q, dist_d;
  logic             fits, at_end, arm;

  generate
    if (FLEXIBLE) begin : g_prefix
      assign fits = 1'b1;
    end else begin : g_strict
      assign fits = 32'(bb_dist_i) < 32'(DEPTH);
    end
  endgenerate

  assign at_end = (state_q != LC_IDLE) && (fetch_pc_i == end_q);
  assign arm    = bb_i && bb_taken_i && !at_end;

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    end_d   = end_q;
    dist_d  = dist_q;
    if (fetch_valid_i) begin
      if (arm) begin
        if (fits) begin
          state_d = LC_FILL;
          start_d = fetch_pc_i - PC_W'(bb_dist_i);
          end_d   = fetch_pc_i;
          dist_d  = bb_dist_i;
        end else begin
          state_d = LC_IDLE;
        end
      end else if (state_q != LC_IDLE) begin
        if (bb_i && bb_taken_i)  state_d = LC_FETCH; // own branch: next pass hits
        else if (cof_i)          state_d = LC_IDLE;
        else if (bb_i && at_end) state_d = LC_IDLE;  // loop exit
        else if (!in_range_i)    state_d = LC_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LC_IDLE;
      start_q <= '0;
      end_q   <= '0;
      dist_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      end_q   <= end_d;
      dist_q  <= dist_d;
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign end_o   = end_q;
  assign dist_o  = dist_q;
endmodule

// File: rtl/loop_cache.sv
module loop_cache
  import loop_cache_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 8,
  parameter int DEPTH    = 32,   // power of two, 8..1024
  parameter bit FLEXIBLE = 1'b0,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic [DATA_W-1:0] l1_data_i,
  input  logic              bb_i,
  input  logic              bb_taken_i,
  input  logic              cof_i,
  input  logic [OFF_W-1:0]  bb_dist_i,
  output logic              sel_buf_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              l1_req_o
);
  lc_state_e        state_w;
  logic [PC_W-1:0]  start_w, end_w;
  logic [OFF_W-1:0] dist_w;
  logic             in_range_w, in_buf_w, hit_w, fill_we;
  logic [IDX_W-1:0] idx_w;

  lc_ctrl #(
    .PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .FLEXIBLE(FLEXIBLE)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_pc_i    (fetch_pc_i),
    .bb_i          (bb_i),
    .bb_taken_i    (bb_taken_i),
    .cof_i         (cof_i),
    .bb_dist_i     (bb_dist_i),
    .in_range_i    (in_range_w),
    .state_o       (state_w),
    .start_o       (start_w),
    .end_o         (end_w),
    .dist_o        (dist_w)
  );

  lc_range #(
    .PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH)
  ) u_range (
    .pc_i       (fetch_pc_i),
    .start_i    (start_w),
    .dist_i     (dist_w),
    .in_range_o (in_range_w),
    .in_buf_o   (in_buf_w),
    .idx_o      (idx_w)
  );

  assign hit_w   = fetch_valid_i && in_range_w && in_buf_w;
  assign fill_we = hit_w && (state_w == LC_FILL);

  lc_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (fill_we),
    .idx_i   (idx_w),
    .wdata_i (l1_data_i),
    .rdata_o (buf_data_o)
  );

  assign sel_buf_o = hit_w && (state_w == LC_FETCH);
  assign l1_req_o  = fetch_valid_i && !sel_buf_o;
endmodule

// File: rtl/loop_cache_chk.sv
module loop_cache_chk
  import loop_cache_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int OFF_W    = 8,
  parameter int DEPTH    = 32,
  parameter bit FLEXIBLE = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_valid_i,
  input logic [PC_W-1:0]  fetch_pc_i,
  input logic             bb_i,
  input logic             bb_taken_i,
  input logic             cof_i,
  input logic             sel_buf_o,
  input logic             l1_req_o,
  input lc_state_e        state_i,
  input logic [PC_W-1:0]  end_i,
  input logic [OFF_W-1:0] dist_i
);
  assert_idle_no_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LC_IDLE) |-> !sel_buf_o);

  assert_fill_from_l1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LC_FILL && fetch_valid_i) |-> (l1_req_o && !sel_buf_o));

  assert_one_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_buf_o && l1_req_o));

  assert_strict_fits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FLEXIBLE && state_i != LC_IDLE) |-> (32'(dist_i) < 32'(DEPTH)));

  assert_cof_aborts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && cof_i && !bb_i) |=> (state_i == LC_IDLE));

  assert_exit_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && bb_i && !bb_taken_i && state_i != LC_IDLE && fetch_pc_i == end_i)
      |=> (state_i == LC_IDLE));

  assert_bubble_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> $stable(state_i));
endmodule

bind loop_cache loop_cache_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .FLEXIBLE(FLEXIBLE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_pc_i    (fetch_pc_i),
  .bb_i          (bb_i),
  .bb_taken_i    (bb_taken_i),
  .cof_i         (cof_i),
  .sel_buf_o     (sel_buf_o),
  .l1_req_o      (l1_req_o),
  .state_i       (state_w),
  .end_i         (end_w),
  .dist_i        (dist_w)
);

// File: tb/loop_cache_tb_top.sv
`timescale 1ns/1ps
module loop_cache_tb_top;
  localparam int PC_W = 16, DATA_W = 32, OFF_W = 8, DEPTH = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fetch_valid_i = 1'b0;
  logic [PC_W-1:0]   fetch_pc_i = '0;
  logic [DATA_W-1:0] l1_data_i = '0;
  logic              bb_i = 1'b0, bb_taken_i = 1'b0, cof_i = 1'b0;
  logic [OFF_W-1:0]  bb_dist_i = '0;
  logic              sel_b, req_b, sel_f, req_f;
  logic [DATA_W-1:0] dat_b, dat_f;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  loop_cache #(.PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .FLEXIBLE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .l1_data_i(l1_data_i), .bb_i(bb_i), .bb_taken_i(bb_taken_i), .cof_i(cof_i),
    .bb_dist_i(bb_dist_i), .sel_buf_o(sel_b), .buf_data_o(dat_b), .l1_req_o(req_b));

  loop_cache #(.PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .FLEXIBLE(1'b1)) dut_flex_i (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .l1_data_i(l1_data_i), .bb_i(bb_i), .bb_taken_i(bb_taken_i), .cof_i(cof_i),
    .bb_dist_i(bb_dist_i), .sel_buf_o(sel_f), .buf_data_o(dat_f), .l1_req_o(req_f));

  function automatic logic [DATA_W-1:0] word_at(input logic [PC_W-1:0] pc);
    return {pc ^ 16'h5A3C, ~pc};
  endfunction

  // row: valid, pc, bb, taken, cof, dist, expected select strict, expected select prefix
  function automatic logic [29:0] row(input logic v, input logic [15:0] pc, input logic bb,
                                      input logic tk, input logic cf, input logic [7:0] d,
                                      input logic eb, input logic ef);
    return {v, pc, bb, tk, cf, d, eb, ef};
  endfunction

  localparam int NROW = 20;
  localparam logic [29:0] VEC [NROW] = '{
    row(1, 16'h10, 0, 0, 0, 0, 0, 0), row(1, 16'h11, 0, 0, 0, 0, 0, 0),
    row(1, 16'h12, 0, 0, 0, 0, 0, 0), row(1, 16'h13, 1, 1, 0, 3, 0, 0),
    row(1, 16'h10, 0, 0, 0, 0, 0, 0), row(1, 16'h11, 0, 0, 0, 0, 0, 0),
    row(1, 16'h12, 0, 0, 0, 0, 0, 0), row(1, 16'h13, 1, 1, 0, 3, 0, 0),
    row(1, 16'h10, 0, 0, 0, 0, 1, 1), row(1, 16'h11, 0, 0, 0, 0, 1, 1),
    row(1, 16'h12, 0, 0, 0, 0, 1, 1), row(1, 16'h13, 1, 1, 0, 3, 1, 1),
    row(1, 16'h10, 0, 0, 0, 0, 1, 1), row(0, 16'h11, 1, 1, 0, 0, 0, 0),
    row(1, 16'h11, 0, 0, 0, 0, 1, 1), row(1, 16'h12, 0, 0, 0, 0, 1, 1),
    row(1, 16'h13, 1, 0, 0, 3, 1, 1), row(1, 16'h14, 0, 0, 0, 0, 0, 0),
    row(1, 16'h15, 0, 0, 0, 0, 0, 0), row(1, 16'h16, 0, 0, 0, 0, 0, 0)
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [PC_W-1:0] pc, input logic bb, input logic tk,
                      input logic cf, input logic [OFF_W-1:0] d, input logic eb, input logic ef,
                      input string rq);
    @(negedge clk);
    fetch_valid_i = v; fetch_pc_i = pc; bb_i = bb; bb_taken_i = tk; cof_i = cf; bb_dist_i = d;
    l1_data_i = (eb || ef) ? 32'hDEAD_BEEF : word_at(pc);
    #1;
    check(sel_b == eb, rq, "strict select", 32'(sel_b), 32'(eb));
    check(req_b == (v && !eb), rq, "strict l1 request", 32'(req_b), 32'(v && !eb));
    if (eb) check(dat_b == word_at(pc), rq, "strict data", dat_b, word_at(pc));
    check(sel_f == ef, rq, "prefix select", 32'(sel_f), 32'(ef));
    check(req_f == (v && !ef), rq, "prefix l1 request", 32'(req_f), 32'(v && !ef));
    if (ef) check(dat_f == word_at(pc), rq, "prefix data", dat_f, word_at(pc));
  endtask

  task automatic pass(input logic [PC_W-1:0] s, input int n, input logic tk,
                      input logic eb, input logic ef, input string rq);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) step(1, s + PC_W'(i), 1, tk, 0, OFF_W'(n - 1), eb, ef, rq);
      else            step(1, s + PC_W'(i), 0, 0, 0, 0, eb, ef, rq);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; fetch_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    step(1, 16'h0, 0, 0, 0, 0, 0, 0, "R1");

    // R2/R3 with R10 bubble and R8 exit, table driven
    for (int i = 0; i < NROW; i++) begin
      logic [29:0] r;
      r = VEC[i];
      step(r[29], r[28:13], r[12], r[11], r[10], r[9:2], r[1], r[0],
           r[29] ? "R2/R3/R8 table" : "R10 bubble");
    end

    // R6: cof while filling aborts; redetect, fill, then serve
    pass(16'h40, 6, 1, 0, 0, "R2");
    step(1, 16'h40, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 16'h41, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 16'h42, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 16'h44, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 16'h45, 1, 1, 0, 5, 0, 0, "R6");
    pass(16'h40, 6, 1, 0, 0, "R6");
    pass(16'h40, 6, 1, 1, 1, "R3");

    // R7: cof while serving ends serving
    step(1, 16'h40, 0, 0, 0, 0, 1, 1, "R7");
    step(1, 16'h41, 0, 0, 0, 0, 1, 1, "R7");
    step(1, 16'h42, 0, 0, 1, 0, 1, 1, "R7");
    step(1, 16'h44, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 16'h45, 1, 1, 0, 5, 0, 0, "R7");

    // R9: inner backward branch while filling rearms to the inner loop
    step(1, 16'h40, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 16'h41, 1, 1, 0, 1, 0, 0, "R9");
    pass(16'h40, 2, 1, 0, 0, "R9");
    pass(16'h40, 2, 1, 1, 1, "R9");
    pass(16'h40, 2, 0, 1, 1, "R9");
    step(1, 16'h42, 0, 0, 0, 0, 0, 0, "R9");

    // R11: leaving the loop range without a flag
    pass(16'h60, 3, 1, 0, 0, "R11");
    pass(16'h60, 3, 1, 0, 0, "R11");
    step(1, 16'h60, 0, 0, 0, 0, 1, 1, "R11");
    step(1, 16'h80, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 16'h60, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 16'h61, 0, 0, 0, 0, 0, 0, "R11");

    // R4/R5: 12-word loop against an 8-entry store
    pass(16'h100, 12, 1, 0, 0, "R4");
    pass(16'h100, 12, 1, 0, 0, "R5");
    for (int i = 0; i < 12; i++) begin
      logic in_pre;
      in_pre = (i < DEPTH);
      step(1, 16'h100 + 16'(i), (i == 11), 0, 0, (i == 11) ? 8'd11 : 8'd0, 0, in_pre,
           in_pre ? "R5 prefix" : "R4/R5 tail");
    end
    step(1, 16'h10C, 0, 0, 0, 0, 0, 0, "R5");

    // R8: re-entry after exit needs detection and fill again
    pass(16'h10, 4, 1, 0, 0, "R8");
    pass(16'h10, 4, 1, 0, 0, "R8");
    step(1, 16'h10, 0, 0, 0, 0, 1, 1, "R8");

    // R1: reset while serving
    do_reset();
    step(1, 16'h11, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 16'h12, 0, 0, 0, 0, 0, 0, "R1");

    @(negedge clk);
    fetch_valid_i = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule